// File: doc/BRIEF.md
# CPU exception entry sequencer

This block moves a processor core into exception processing. A requester presents a vector offset, a program counter, the current status word, the active and supervisor stack pointers, the vector base and the core generation. The sequencer captures all of them in one cycle and first screens them for alignment faults. It then switches to the supervisor stack and pushes a three-word frame through a word-wide memory port. Next it reads the 32-bit handler address at vector base plus offset. Finally it hands back the new program counter, the new status word and the new supervisor stack pointer, and it pulses a wake signal that releases a stopped core.

Some alignment faults would only cause another exception of the same kind. For these the sequencer gives up and pulses a reset request instead of looping. Every finished entry, whether it succeeds or ends on the reset path, reports a cycle cost. The core's timing model charges that cost.

Top module: `exc_entry_seq`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. From that edge through the cycle of the `exc_done` or `fail_reset` pulse, `req_ready` stays low and further requests are ignored. A held request is therefore processed once per acceptance.
- R2: If bit 0 of `vec_base` is set, the entry is abandoned with no memory access. This holds for every vector and every generation. `fail_reset` pulses with `cost` = 132.
- R3: A generation counts as strict when `core_gen` < 2. For a strict generation with offset 0x0C, the entry fails before any memory access in either of two cases: bit 0 of `req_sp` is set, or bit 0 of the switched stack pointer S is set. S is `req_sp` when `req_sr` bit 13 is 1, and `req_ssp` otherwise. Odd stack pointers do not fail on other vectors or on generations 2 and 3.
- R4: For a strict generation with offset 0x0C, a handler address with bit 0 set ends the entry on the reset path after the frame writes, with `cost` = 132 and no `exc_done`.
- R5: The frame is three word writes. The low half of the saved PC goes to S-2, then the high half to S-4, then the status word captured at acceptance to S-6. `new_ssp` is S-6.
- R6: The saved PC is `req_pc` - 2 for offset 0x0C and `req_pc` for every other offset.
- R7: After the frame, one read (`mem_we` = 0) at `vec_base` + offset returns the handler address, which appears on `new_pc`.
- R8: On success, `exc_done` and `resume_core` pulse together. `new_sr` equals the captured status word with bit 13 set and bits 15 and 14 cleared.
- R9: `cost` on `exc_done` is as follows:
  - 50 for offsets 0x08 and 0x0C;
  - 42 for 0x14;
  - 28 for 0x18;
  - 34 for 0x10, 0x1C, 0x20, 0x24, 0x28 and 0x2C, and for the trap offsets 0x80 + 4n with n from 0 to 15;
  - 4 for any other offset.

  `cost` is 0 when neither pulse is high.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_offset | input | 8 | Vector offset in bytes |
| req_pc | input | 32 | Program counter supplied with the request |
| req_sr | input | 16 | Status word before the exception |
| req_sp | input | 32 | Active stack pointer |
| req_ssp | input | 32 | Supervisor stack pointer |
| vec_base | input | 32 | Vector base address |
| core_gen | input | 2 | Core generation, 0 to 3 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = word write, 0 = long read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| exc_done | output | 1 | Successful entry pulse |
| resume_core | output | 1 | Release a stopped core |
| fail_reset | output | 1 | Double-fault reset request pulse |
| cost | output | 8 | Cycle cost, valid with a pulse |
| new_pc | output | 32 | Handler address |
| new_sr | output | 16 | Status word after entry |
| new_ssp | output | 32 | Supervisor stack pointer after the frame |

## Verification
The completion pulse and a fresh request can land in the same cycle. The bench holds `req_valid` high through an entire entry and swaps the request fields at the moment `exc_done` shows. It requires `req_ready` to be low in that cycle, exactly three frame writes for the first entry, and a second frame that carries only the swapped values. A second overlap is the handler-read acknowledge and the late alignment verdict. These share one edge, and the bench judges them by requiring the reset pulse with full frame writes but no done pulse.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 16;
    localparam int OFF_W  = 8;

    localparam logic [OFF_W-1:0] OFF_BUS_ERR  = 8'h08;
    localparam logic [OFF_W-1:0] OFF_ADDR_ERR = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_ILLEGAL  = 8'h10;
    localparam logic [OFF_W-1:0] OFF_DIV0     = 8'h14;
    localparam logic [OFF_W-1:0] OFF_BOUND    = 8'h18;
    localparam logic [OFF_W-1:0] OFF_CONDTRAP = 8'h1C;
    localparam logic [OFF_W-1:0] OFF_PRIV     = 8'h20;
    localparam logic [OFF_W-1:0] OFF_TRACE    = 8'h24;
    localparam logic [OFF_W-1:0] OFF_EMU_A    = 8'h28;
    localparam logic [OFF_W-1:0] OFF_EMU_F    = 8'h2C;
    localparam logic [OFF_W-1:0] OFF_TRAP_LO  = 8'h80;
    localparam logic [OFF_W-1:0] OFF_TRAP_HI  = 8'hBC;

    localparam logic [WORD_W-1:0] SR_SUPER = 16'h2000;
    localparam logic [WORD_W-1:0] SR_KEEP  = 16'h3FFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_PUSH_SR,
        ST_FETCH,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [ADDR_W-1:0] saved_pc;
        logic [WORD_W-1:0] sr;
        logic [ADDR_W-1:0] sp_pre;
        logic [ADDR_W-1:0] sp_sup;
        logic [ADDR_W-1:0] vbase;
        logic              strict;
    } exc_ctx_t;

    function automatic logic trap_vector(input logic [OFF_W-1:0] off);
        return (off >= OFF_TRAP_LO) && (off <= OFF_TRAP_HI) && (off[1:0] == 2'b00);
    endfunction

    function automatic int unsigned vector_cost(input logic [OFF_W-1:0] off);
        int unsigned c;
        case (off)
            OFF_BUS_ERR, OFF_ADDR_ERR: c = 50;
            OFF_DIV0:                  c = 42;
            OFF_BOUND:                 c = 28;
            OFF_ILLEGAL, OFF_CONDTRAP, OFF_PRIV,
            OFF_TRACE, OFF_EMU_A, OFF_EMU_F: c = 34;
            default:                   c = trap_vector(off) ? 34 : 4;
        endcase
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] enter_sr(input logic [WORD_W-1:0] sr);
        return (sr | SR_SUPER) & SR_KEEP;
    endfunction

endpackage

// File: rtl/exc_align_check.sv
module exc_align_check
    import exc_pkg::*;
(
    input  exc_ctx_t          ctx,
    input  logic [ADDR_W-1:0] handler,
    output logic              early_fail,
    output logic              late_fail
);
    logic strict_ae;

    always_comb begin
        strict_ae  = ctx.strict && (ctx.off == OFF_ADDR_ERR);
        early_fail = ctx.vbase[0] || (strict_ae && (ctx.sp_pre[0] || ctx.sp_sup[0]));
        late_fail  = strict_ae && handler[0];
    end
endmodule

// File: rtl/exc_cost_sel.sv
module exc_cost_sel
    import exc_pkg::*;
#(
    parameter int COST_W    = 8,
    parameter int FAIL_COST = 132
) (
    input  logic [OFF_W-1:0]  off,
    input  logic              fail_path,
    output logic [COST_W-1:0] cost
);
    always_comb begin
        if (fail_path) cost = COST_W'(FAIL_COST);
        else           cost = COST_W'(vector_cost(off));
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int COST_W           = 8,
    parameter int GEN_W            = 2,
    parameter int STRICT_GEN_LIMIT = 2,
    parameter int FAIL_COST        = 132,
    parameter int FRAME_WORDS      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_offset,
    input  logic [31:0]       req_pc,
    input  logic [15:0]       req_sr,
    input  logic [31:0]       req_sp,
    input  logic [31:0]       req_ssp,
    input  logic [31:0]       vec_base,
    input  logic [GEN_W-1:0]  core_gen,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              exc_done,
    output logic              resume_core,
    output logic              fail_reset,
    output logic [COST_W-1:0] cost,
    output logic [31:0]       new_pc,
    output logic [15:0]       new_sr,
    output logic [31:0]       new_ssp
);
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;

    seq_state_t        state;
    exc_ctx_t          ctx;
    logic [ADDR_W-1:0] handler;
    logic              accept;
    logic              early_fail;
    logic              late_fail_now;
    logic              late_fail_reg;
    logic              unused_late;
    logic [COST_W-1:0] cost_sel;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    exc_align_check u_early (
        .ctx        (ctx),
        .handler    (handler),
        .early_fail (early_fail),
        .late_fail  (late_fail_reg)
    );

    exc_align_check u_late (
        .ctx        (ctx),
        .handler    (mem_rdata),
        .early_fail (unused_late),
        .late_fail  (late_fail_now)
    );

    exc_cost_sel #(.COST_W(COST_W), .FAIL_COST(FAIL_COST)) u_cost (
        .off       (ctx.off),
        .fail_path (state == ST_FAIL),
        .cost      (cost_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctx     <= '0;
            handler <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    ctx.off      <= req_offset;
                    ctx.saved_pc <= (req_offset == OFF_ADDR_ERR) ? req_pc - 32'd2 : req_pc;
                    ctx.sr       <= req_sr;
                    ctx.sp_pre   <= req_sp;
                    ctx.sp_sup   <= req_sr[13] ? req_sp : req_ssp;
                    ctx.vbase    <= vec_base;
                    ctx.strict   <= (core_gen < GEN_W'(STRICT_GEN_LIMIT));
                    state        <= ST_CHECK;
                end
                ST_CHECK:   state <= early_fail ? ST_FAIL : ST_PUSH_LO;
                ST_PUSH_LO: if (mem_ack) state <= ST_PUSH_HI;
                ST_PUSH_HI: if (mem_ack) state <= ST_PUSH_SR;
                ST_PUSH_SR: if (mem_ack) state <= ST_FETCH;
                ST_FETCH: if (mem_ack) begin
                    handler <= mem_rdata;
                    state   <= late_fail_now ? ST_FAIL : ST_DONE;
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAIL:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_LO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx.sp_sup - 32'(WORD_BYTES);
                mem_wdata = ctx.saved_pc[15:0];
            end
            ST_PUSH_HI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx.sp_sup - 32'(2 * WORD_BYTES);
                mem_wdata = ctx.saved_pc[31:16];
            end
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx.sp_sup - 32'(3 * WORD_BYTES);
                mem_wdata = ctx.sr;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ctx.vbase + 32'(ctx.off);
            end
            default: ;
        endcase
    end

    assign exc_done    = (state == ST_DONE);
    assign resume_core = exc_done;
    assign fail_reset  = (state == ST_FAIL);
    assign cost        = (exc_done || fail_reset) ? cost_sel : '0;
    assign new_pc      = handler;
    assign new_sr      = enter_sr(ctx.sr);
    assign new_ssp     = ctx.sp_sup - 32'(FRAME_BYTES);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    assert_nomem_fail_R2: assert property (@(posedge clk) disable iff (rst)
        fail_reset |-> !mem_req);

    assert_sr_bits_R8: assert property (@(posedge clk) disable iff (rst)
        exc_done |-> (new_sr[13] && !new_sr[15] && !new_sr[14]));

    assert_even_handler_R4: assert property (@(posedge clk) disable iff (rst)
        exc_done |-> !late_fail_reg);

    assert_cost_R9: assert property (@(posedge clk) disable iff (rst)
        (exc_done || fail_reset) |-> (cost != '0));

    assert_onepulse_R1: assert property (@(posedge clk) disable iff (rst)
        !(exc_done && fail_reset));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    typedef struct packed {
        logic [7:0]  off;
        logic [1:0]  gen;
        logic [15:0] sr;
        logic [31:0] pc;
        logic [31:0] a7;
        logic [31:0] ssp;
        logic [31:0] vbr;
        logic [31:0] hnd;
        logic [1:0]  lat;
    } vec_t;

    localparam vec_t VT [NVEC] = '{
        '{8'h08, 2'd0, 16'h8015, 32'h00001F00, 32'h1000, 32'h2000, 32'h0,    32'h4000, 2'd0},
        '{8'h0C, 2'd3, 16'h2700, 32'h12345678, 32'h3001, 32'h0,    32'h100,  32'h5001, 2'd1},
        '{8'h0C, 2'd0, 16'h0000, 32'h00000400, 32'h1001, 32'h2000, 32'h0,    32'h6000, 2'd0},
        '{8'h0C, 2'd1, 16'h0000, 32'h00000400, 32'h1000, 32'h2001, 32'h0,    32'h6000, 2'd0},
        '{8'h0C, 2'd0, 16'h2000, 32'h00000500, 32'h1000, 32'h0,    32'h0,    32'h6001, 2'd1},
        '{8'h0C, 2'd1, 16'hA704, 32'h00000600, 32'h1000, 32'h2000, 32'h0,    32'h6000, 2'd2},
        '{8'h10, 2'd3, 16'h0000, 32'h00000700, 32'h1000, 32'h2000, 32'h1,    32'h6000, 2'd0},
        '{8'h14, 2'd2, 16'h4000, 32'h00000800, 32'h1000, 32'h2000, 32'h200,  32'h7000, 2'd2},
        '{8'h18, 2'd0, 16'h0000, 32'h00000900, 32'h1000, 32'h2000, 32'h0,    32'h7004, 2'd0},
        '{8'hBC, 2'd2, 16'h0000, 32'h00000A00, 32'h1000, 32'h2000, 32'h8000, 32'h7008, 2'd1},
        '{8'h80, 2'd3, 16'h0000, 32'h00000B00, 32'h1000, 32'h2000, 32'h0,    32'h700C, 2'd0},
        '{8'h38, 2'd3, 16'h0000, 32'h00000C00, 32'h1000, 32'h2000, 32'h0,    32'h7010, 2'd0},
        '{8'h1C, 2'd0, 16'h0000, 32'h00000D00, 32'h1000, 32'h2000, 32'h0,    32'h7014, 2'd0},
        '{8'h2C, 2'd1, 16'h2000, 32'h00000E00, 32'h1001, 32'h0,    32'h0,    32'h7018, 2'd1},
        '{8'h0C, 2'd0, 16'h2000, 32'h00000F00, 32'h1000, 32'h0,    32'h3,    32'h7020, 2'd0},
        '{8'h20, 2'd3, 16'hC000, 32'h00001100, 32'h1000, 32'h2000, 32'h0,    32'h7024, 2'd0},
        '{8'h86, 2'd2, 16'h0000, 32'h00001200, 32'h1000, 32'h2000, 32'h0,    32'h7028, 2'd0}
    };

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_ready;
    logic [7:0] req_offset = 0;
    logic [31:0] req_pc = 0, req_sp = 0, req_ssp = 0, vec_base = 0;
    logic [15:0] req_sr = 0;
    logic [1:0] core_gen = 0;
    logic mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr, mem_rdata = 0;
    logic [15:0] mem_wdata;
    logic exc_done, resume_core, fail_reset;
    logic [7:0] cost;
    logic [31:0] new_pc, new_ssp;
    logic [15:0] new_sr;

    exc_entry_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_pc(req_pc), .req_sr(req_sr), .req_sp(req_sp),
        .req_ssp(req_ssp), .vec_base(vec_base), .core_gen(core_gen),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .exc_done(exc_done),
        .resume_core(resume_core), .fail_reset(fail_reset), .cost(cost),
        .new_pc(new_pc), .new_sr(new_sr), .new_ssp(new_ssp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nfail = 0, finished = 0;
    int lat = 0, wcnt = 0, nw = 0, nr = 0, unstable = 0;
    logic [31:0] cur_hnd = 0, rd_addr = 0;
    logic [31:0] wa [0:7];
    logic [15:0] wd [0:7];
    logic pend = 0, pw = 0;
    logic [31:0] pa = 0;
    logic [15:0] pd = 0;

    // memory responder, acts at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 0;
            if (mem_req && pend && (mem_addr != pa || mem_wdata != pd || mem_we != pw))
                unstable++;
            if (mem_req) begin
                if (wcnt >= lat) begin
                    mem_ack = 1;
                    wcnt = 0;
                    pend = 0;
                    if (mem_we) begin
                        if (nw < 8) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
                        nw++;
                    end else begin
                        rd_addr = mem_addr;
                        mem_rdata = cur_hnd;
                        nr++;
                    end
                end else begin
                    wcnt++;
                    pend = 1; pa = mem_addr; pd = mem_wdata; pw = mem_we;
                end
            end else pend = 0;
        end
    end

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_cost(input logic [7:0] o);
        if (o == 8'h08 || o == 8'h0C) return 50;
        if (o == 8'h14) return 42;
        if (o == 8'h18) return 28;
        if (o == 8'h10 || o == 8'h1C || o == 8'h20 || o == 8'h24 || o == 8'h28 || o == 8'h2C) return 34;
        if (o >= 8'h80 && o <= 8'hBC && (o % 4) == 0) return 34;
        return 4;
    endfunction

    task automatic drive(input vec_t v);
        req_offset = v.off; req_pc = v.pc; req_sr = v.sr; req_sp = v.a7;
        req_ssp = v.ssp; vec_base = v.vbr; core_gen = v.gen;
        lat = v.lat; cur_hnd = v.hnd; nw = 0; nr = 0;
    endtask

    task automatic wait_end;
        int t = 0;
        while (!(exc_done || fail_reset) && t < 200) begin @(negedge clk); t++; end
    endtask

    task automatic judge(input vec_t v);
        logic strict, ae, early, late;
        logic [31:0] s, spc;
        strict = v.gen < 2;
        ae = (v.off == 8'h0C);
        s = v.sr[13] ? v.a7 : v.ssp;
        spc = ae ? v.pc - 32'd2 : v.pc;
        early = v.vbr[0] || (strict && ae && (v.a7[0] || s[0]));
        late = !early && strict && ae && v.hnd[0];
        if (early) begin
            chk(v.vbr[0] ? "R2 fail pulse" : "R3 fail pulse", {31'b0, fail_reset}, 1);
            chk("R2/R3 cost 132", {24'b0, cost}, 132);
            chk("R3 no memory writes", nw, 0);
        end else if (late) begin
            chk("R4 fail pulse", {31'b0, fail_reset}, 1);
            chk("R4 no done", {31'b0, exc_done}, 0);
            chk("R4 cost 132", {24'b0, cost}, 132);
            chk("R4 frame written", nw, 3);
        end else begin
            chk("R8 done", {31'b0, exc_done}, 1);
            chk("R8 resume", {31'b0, resume_core}, 1);
            chk("R9 cost", {24'b0, cost}, exp_cost(v.off));
            chk("R8 new_sr", {16'b0, new_sr}, {16'b0, (v.sr | 16'h2000) & 16'h3FFF});
            chk("R7 new_pc", new_pc, v.hnd);
            chk("R7 read addr", rd_addr, v.vbr + {24'b0, v.off});
            chk("R5 new_ssp", new_ssp, s - 32'd6);
            chk("R5 write count", nw, 3);
            chk("R5 addr0", wa[0], s - 32'd2);
            chk("R6 pc low", {16'b0, wd[0]}, {16'b0, spc[15:0]});
            chk("R5 addr1", wa[1], s - 32'd4);
            chk("R6 pc high", {16'b0, wd[1]}, {16'b0, spc[31:16]});
            chk("R5 addr2", wa[2], s - 32'd6);
            chk("R5 sr word", {16'b0, wd[2]}, {16'b0, v.sr});
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset ready", {31'b0, req_ready}, 1);
        chk("R10 reset no mem_req", {31'b0, mem_req}, 0);
        chk("R8 reset no done", {31'b0, exc_done}, 0);
        chk("R2 reset no fail", {31'b0, fail_reset}, 0);
        chk("R9 reset cost 0", {24'b0, cost}, 0);

        for (int i = 0; i < NVEC; i++) begin
            while (!req_ready) @(negedge clk);
            drive(VT[i]);
            req_valid = 1;
            @(negedge clk);
            req_valid = 0;
            chk("R1 busy after accept", {31'b0, req_ready}, 0);
            wait_end();
            judge(VT[i]);
            @(negedge clk);
        end

        // held request meets the done pulse (R1)
        drive(VT[0]);
        req_valid = 1;
        @(negedge clk);
        wait_end();
        chk("R1 ready low at done", {31'b0, req_ready}, 0);
        chk("R1 single frame while held", nw, 3);
        drive(VT[7]);
        @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        wait_end();
        judge(VT[7]);
        repeat (4) @(negedge clk);
        chk("R1 no further entry", {31'b0, mem_req}, 0);

        chk("R10 port stable while waiting", unstable, 0);

        finished = 1;
        report();
        $finish;
    end
endmodule